// File: doc/BRIEF.md
# H-Bridge Commutation Gate Sequencer

This block produces the four gate-enable signals of a full bridge driving the single winding of a brushless fan. It takes the digitized polarity of the rotor position sensor, a PWM on/off request, an early slow-decay request and a global fault flag. From these it picks which diagonal of the bridge conducts and puts both low-side switches on to recirculate winding current. It spaces every switch change within a leg by a dead-time interval and removes all drive while a fault is present.

The sensor polarity first passes a synchronizer and a glitch filter. A level change counts only after it has held for a programmable number of clock cycles. The filtered polarity selects the drive direction and is also output as the speed tachometer signal. When PWM is off or a slow-decay request is present, the high-side switches open and both low-side switches conduct. Each leg of the bridge has its own dead-time counter. A gate of a leg can turn on only after both gates of that leg have been off for the whole interval. This rule also covers the first turn-on after reset and after a fault clears.

Top module: `hbridge_gate_seq`

## Requirements
- R1: A change of the synchronized sensor polarity that lasts fewer than HALL_REJECT_CYC consecutive clock cycles leaves `fg` and the drive direction unchanged.
- R2: The filtered polarity takes the synchronized value after HALL_REJECT_CYC consecutive differing cycles. `fg` always equals the filtered polarity, so it toggles once per accepted transition.
- R3: With PWM on, no slow-decay request and no fault, filtered polarity 1 settles to `gate_hi_a` and `gate_lo_b` on with the other two gates off. Polarity 0 settles to `gate_hi_b` and `gate_lo_a` on with the other two off.
- R4: With PWM off and no fault, both high-side gates are off. After dead time both low-side gates are on (synchronous rectification).
- R5: A slow-decay request overrides PWM on and produces the same low-side recirculation pattern as R4.
- R6: The high-side and low-side gates of the same leg are never on in the same cycle.
- R7: A gate that is no longer requested turns off at the next clock edge. Its leg partner turns on only after both gates of the leg have been off for DEAD_CYC+1 clock cycles.
- R8: While `fault` is high, all four gate outputs are low in the same cycle, without waiting for a clock edge.
- R9: After reset, and after `fault` falls, every gate stays off for DEAD_CYC+1 cycles before any gate turns on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_in | input | 1 | Digitized sensor polarity (asynchronous) |
| pwm_on | input | 1 | PWM request, 1 = drive the winding, 0 = recirculate |
| slow_decay_req | input | 1 | Early slow-decay request ahead of commutation |
| fault | input | 1 | Global fault, 1 = all gates off |
| gate_hi_a | output | 1 | High-side gate, leg A |
| gate_lo_a | output | 1 | Low-side gate, leg A |
| gate_hi_b | output | 1 | High-side gate, leg B |
| gate_lo_b | output | 1 | Low-side gate, leg B |
| fg | output | 1 | Tachometer output, equal to filtered polarity |

## Verification
Sensor pulses one cycle shorter than the reject window and exactly as long as it are applied. They separate a filter that passes glitches from one that drops valid edges. PWM-off and slow-decay requests are issued in both polarities, which tells a correct low-side recirculation from a diagonal held on or a bridge left fully open. Dead time is probed on the turn-off edge, on the last off cycle and on the turn-on cycle, so an off-by-one counter is caught. Fault pulses and a long random stream of all four inputs are also compared against the reference model.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

   // gate pair of one bridge leg
   typedef struct packed {
      logic hi;
      logic lo;
   } leg_pair_t;

   localparam int unsigned NUM_LEGS = 2;
   localparam int unsigned LEG_A    = 0;
   localparam int unsigned LEG_B    = 1;

   localparam leg_pair_t PAIR_OFF  = '{hi: 1'b0, lo: 1'b0};
   localparam leg_pair_t PAIR_HIGH = '{hi: 1'b1, lo: 1'b0};
   localparam leg_pair_t PAIR_LOW  = '{hi: 1'b0, lo: 1'b1};

endpackage

// File: rtl/hbs_hall_filter.sv
module hbs_hall_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned REJECT_CYC  = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hall_in,
   output logic hall_sync,
   output logic hall_filt
);

   localparam int unsigned CW = (REJECT_CYC > 1) ? $clog2(REJECT_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(REJECT_CYC - 1);

   // synchronizer depth picked by parameter
   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign hall_sync = hall_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr <= '0;
            end else begin
               sr[0] <= hall_in;
               for (int i = 1; i < int'(SYNC_STAGES); i++) begin
                  sr[i] <= sr[i-1];
               end
            end
         end
         assign hall_sync = sr[SYNC_STAGES-1];
      end
   endgenerate

   logic [CW-1:0] run_cnt;

   // accept a level only after REJECT_CYC consecutive differing samples
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hall_filt <= 1'b0;
         run_cnt   <= '0;
      end else if (hall_sync == hall_filt) begin
         run_cnt <= '0;
      end else if (run_cnt == LAST) begin
         hall_filt <= hall_sync;
         run_cnt   <= '0;
      end else begin
         run_cnt <= run_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/hbs_leg.sv
module hbs_leg
   import hbs_pkg::*;
#(
   parameter int unsigned DEAD_CYC = 200
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      fault,
   input  leg_pair_t req,
   output leg_pair_t gate
);

   localparam int unsigned CW = $clog2(DEAD_CYC + 1);
   localparam logic [CW-1:0] DEAD_V = CW'(DEAD_CYC);

   leg_pair_t     cur;
   logic [CW-1:0] off_cnt;
   logic          drop;

   // a conducting gate that is no longer wanted
   assign drop = (cur.hi && !req.hi) || (cur.lo && !req.lo);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur     <= PAIR_OFF;
         off_cnt <= '0;
      end else if (fault || drop) begin
         cur     <= PAIR_OFF;
         off_cnt <= '0;
      end else if (cur == PAIR_OFF) begin
         if (off_cnt == DEAD_V) begin
            cur <= req;
         end else begin
            off_cnt <= off_cnt + 1'b1;
         end
      end
   end

   // fault removes drive without waiting for an edge
   assign gate = fault ? PAIR_OFF : cur;

endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
   import hbs_pkg::*;
#(
   parameter int unsigned HALL_SYNC_STAGES = 2,
   parameter int unsigned HALL_REJECT_CYC  = 400,
   parameter int unsigned DEAD_CYC         = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hall_in,
   input  logic pwm_on,
   input  logic slow_decay_req,
   input  logic fault,
   output logic gate_hi_a,
   output logic gate_lo_a,
   output logic gate_hi_b,
   output logic gate_lo_b,
   output logic fg
);

   generate
      if (HALL_REJECT_CYC < 1) begin : g_bad_reject
         $error("HALL_REJECT_CYC must be at least 1");
      end
      if (DEAD_CYC < 1) begin : g_bad_dead
         $error("DEAD_CYC must be at least 1");
      end
   endgenerate

   logic      hall_sync;
   logic      hall_filt;
   logic      recirc;
   leg_pair_t req  [NUM_LEGS];
   leg_pair_t gate [NUM_LEGS];

   hbs_hall_filter #(
      .SYNC_STAGES (HALL_SYNC_STAGES),
      .REJECT_CYC  (HALL_REJECT_CYC)
   ) u_filt (
      .clk       (clk),
      .rst_n     (rst_n),
      .hall_in   (hall_in),
      .hall_sync (hall_sync),
      .hall_filt (hall_filt)
   );

   assign recirc = slow_decay_req || !pwm_on;

   // direction and recirculation selection
   always_comb begin
      if (recirc) begin
         req[LEG_A] = PAIR_LOW;
         req[LEG_B] = PAIR_LOW;
      end else if (hall_filt) begin
         req[LEG_A] = PAIR_HIGH;
         req[LEG_B] = PAIR_LOW;
      end else begin
         req[LEG_A] = PAIR_LOW;
         req[LEG_B] = PAIR_HIGH;
      end
   end

   generate
      for (genvar g = 0; g < int'(NUM_LEGS); g++) begin : g_leg
         hbs_leg #(
            .DEAD_CYC (DEAD_CYC)
         ) u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .fault (fault),
            .req   (req[g]),
            .gate  (gate[g])
         );
      end
   endgenerate

   assign gate_hi_a = gate[LEG_A].hi;
   assign gate_lo_a = gate[LEG_A].lo;
   assign gate_hi_b = gate[LEG_B].hi;
   assign gate_lo_b = gate[LEG_B].lo;
   assign fg        = hall_filt;

endmodule

// File: rtl/hbs_checker.sv
module hbs_checker #(
   parameter int unsigned DEAD_CYC = 200
) (
   input logic clk,
   input logic rst_n,
   input logic fault,
   input logic pwm_on,
   input logic slow_decay_req,
   input logic hall_q,
   input logic ha,
   input logic la,
   input logic hb,
   input logic lb,
   input logic fg
);

   int off_a;
   int off_b;

   // independent count of cycles each leg has been fully off
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_a <= 0;
         off_b <= 0;
      end else begin
         off_a <= (ha || la) ? 0 : ((off_a > int'(DEAD_CYC)) ? off_a : off_a + 1);
         off_b <= (hb || lb) ? 0 : ((off_b > int'(DEAD_CYC)) ? off_b : off_b + 1);
      end
   end

   p_leg_a_excl_r6: assert property (@(posedge clk) disable iff (!rst_n) !(ha && la));
   p_leg_b_excl_r6: assert property (@(posedge clk) disable iff (!rst_n) !(hb && lb));

   p_fault_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !(ha || la || hb || lb));

   p_dead_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ha) || $rose(la)) |-> (off_a >= int'(DEAD_CYC) + 1));
   p_dead_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hb) || $rose(lb)) |-> (off_b >= int'(DEAD_CYC) + 1));

   p_fg_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fg) |-> (fg == $past(hall_q)));

   p_dir_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ha) |-> $past(fg));
   p_dir_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hb) |-> !$past(fg));

   p_recirc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ha) || $rose(hb)) |-> $past(pwm_on && !slow_decay_req));

endmodule

bind hbridge_gate_seq hbs_checker #(
   .DEAD_CYC (DEAD_CYC)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .fault          (fault),
   .pwm_on         (pwm_on),
   .slow_decay_req (slow_decay_req),
   .hall_q         (hall_sync),
   .ha             (gate_hi_a),
   .la             (gate_lo_a),
   .hb             (gate_hi_b),
   .lb             (gate_lo_b),
   .fg             (fg)
);

// File: tb/tb_hbridge_gate_seq.sv
`timescale 1ns/100ps
module tb_hbridge_gate_seq;

   localparam int SYNC = 2;
   localparam int REJ  = 8;
   localparam int DEAD = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hall_in = 1'b0;
   logic pwm_on = 1'b1;
   logic slow_decay_req = 1'b0;
   logic fault = 1'b0;
   logic gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b, fg;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   hbridge_gate_seq #(
      .HALL_SYNC_STAGES (SYNC),
      .HALL_REJECT_CYC  (REJ),
      .DEAD_CYC         (DEAD)
   ) dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .hall_in        (hall_in),
      .pwm_on         (pwm_on),
      .slow_decay_req (slow_decay_req),
      .fault          (fault),
      .gate_hi_a      (gate_hi_a),
      .gate_lo_a      (gate_lo_a),
      .gate_hi_b      (gate_hi_b),
      .gate_lo_b      (gate_lo_b),
      .fg             (fg)
   );

   always #2.5 clk = ~clk;

   wire [3:0] gates = {gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b};

   // ---------------- behavioural reference model ----------------
   int q[$];
   int m_filt, m_run;
   int m_hi[2], m_lo[2], m_off[2];

   task automatic model_reset();
      q.delete();
      for (int i = 0; i < SYNC; i++) q.push_front(0);
      m_filt = 0;
      m_run  = 0;
      for (int l = 0; l < 2; l++) begin
         m_hi[l] = 0; m_lo[l] = 0; m_off[l] = 0;
      end
   endtask

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   initial model_reset();

   always @(posedge clk) begin
      int want_hi[2], want_lo[2];
      int hs;
      int exp_g;
      if (!rst_n) begin
         model_reset();
      end else begin
         // wanted pattern from state before this edge
         if (slow_decay_req || !pwm_on) begin
            want_hi[0] = 0; want_lo[0] = 1; want_hi[1] = 0; want_lo[1] = 1;
         end else if (m_filt == 1) begin
            want_hi[0] = 1; want_lo[0] = 0; want_hi[1] = 0; want_lo[1] = 1;
         end else begin
            want_hi[0] = 0; want_lo[0] = 1; want_hi[1] = 1; want_lo[1] = 0;
         end
         for (int l = 0; l < 2; l++) begin
            if (fault || (m_hi[l] == 1 && want_hi[l] == 0) || (m_lo[l] == 1 && want_lo[l] == 0)) begin
               m_hi[l] = 0; m_lo[l] = 0; m_off[l] = 0;
            end else if (m_hi[l] == 0 && m_lo[l] == 0) begin
               if (m_off[l] >= DEAD) begin
                  m_hi[l] = want_hi[l]; m_lo[l] = want_lo[l];
               end else begin
                  m_off[l]++;
               end
            end
         end
         q.push_front(int'(hall_in));
         hs = q.pop_back();
         if (hs == m_filt) m_run = 0;
         else if (m_run == REJ - 1) begin m_filt = hs; m_run = 0; end
         else m_run++;
      end
      #1;
      exp_g = fault ? 0 : ((m_hi[0] << 3) | (m_lo[0] << 2) | (m_hi[1] << 1) | m_lo[1]);
      check("R3/R7 gates per-cycle", int'(gates), exp_g);
      check("R1/R2 fg per-cycle", int'(fg), m_filt);
   end

   // ---------------- directed stimulus ----------------
   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      hold(4);
      check("R9 reset state gates", int'(gates), 0);
      check("R9 reset state fg", int'(fg), 0);
      rst_n = 1'b1;
      hold(3);
      check("R9 off after reset", int'(gates), 0);
      hold(20);
      check("R3 polarity 0 drive", int'(gates), 4'b0110);
      check("R2 fg low", int'(fg), 0);

      // R1: glitch shorter than the window
      hall_in = 1'b1; hold(REJ - 1); hall_in = 1'b0;
      hold(20);
      check("R1 short pulse fg", int'(fg), 0);
      check("R1 short pulse gates", int'(gates), 4'b0110);

      hall_in = 1'b1; hold(30);
      check("R2 accepted edge fg", int'(fg), 1);
      check("R3 polarity 1 drive", int'(gates), 4'b1001);

      pwm_on = 1'b0; hold(20);
      check("R4 pwm off recirculation", int'(gates), 4'b0101);
      pwm_on = 1'b1; hold(20);
      check("R3 pwm back on", int'(gates), 4'b1001);

      slow_decay_req = 1'b1; hold(20);
      check("R5 slow decay", int'(gates), 4'b0101);
      slow_decay_req = 1'b0; hold(20);

      // R7 dead-time timing
      pwm_on = 1'b0; hold(1);
      check("R7 high side off next edge", int'(gates), 4'b0001);
      hold(DEAD);
      check("R7 still in dead time", int'(gates), 4'b0001);
      hold(1);
      check("R7 low side on after dead time", int'(gates), 4'b0101);
      pwm_on = 1'b1; hold(1);
      check("R7 low side off next edge", int'(gates), 4'b0001);
      hold(DEAD + 1);
      check("R7 high side on after dead time", int'(gates), 4'b1001);

      // R8 / R9 fault
      fault = 1'b1; #1;
      check("R8 fault same cycle", int'(gates), 0);
      hold(5);
      check("R8 fault held", int'(gates), 0);
      fault = 1'b0; hold(DEAD);
      check("R9 off after fault release", int'(gates), 0);
      hold(2);
      check("R9 drive after release", int'(gates), 4'b1001);

      // R2 boundary: pulse exactly the window long
      hall_in = 1'b0; hold(REJ); hall_in = 1'b1;
      hold(SYNC + 1);
      check("R2 exact window accepted", int'(fg), 0);
      hold(30);
      check("R2 returns high", int'(fg), 1);

      // random stream, compared every cycle against the model
      for (int k = 0; k < 600; k++) begin
         hall_in        = ($urandom_range(0, 1) == 1);
         pwm_on         = ($urandom_range(0, 3) != 0);
         slow_decay_req = ($urandom_range(0, 7) == 0);
         fault          = ($urandom_range(0, 30) == 0);
         hold($urandom_range(1, 2 * REJ));
      end
      fault = 1'b0;
      hold(40);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule